// File: doc/BRIEF.md
# Interlocked Dual-Phase PWM Generator

This block drives two related pulse-width outputs from one free-running up-counter. The count runs from zero to a programmable period value and then wraps. Each period opens with the auxiliary output low. The auxiliary output then pulses high between a start mark and an end mark. After that, the main switch output turns on at a later mark and stays on until the period ends.

A cycle-by-cycle limit input, typically driven by a current comparator, can end the main on-phase early. It never touches the counter, so the period length and the auxiliary timing of the next period stay exactly as programmed.

Software writes the four timing values into a staging set and then pulses a commit strobe. The committed set waits until the counter wraps, so all four values change together on a period boundary. A half-written set is never used. Marks written in the wrong order are clamped each period, so the two outputs never overlap.

Top module: `dpwm_interlock`

## Requirements
- R1: While `run_en` is low, `aux_out` and `main_out` are low and the counter is held at zero. After `run_en` rises, the first period starts from count zero.
- R2: With `run_en` high, the counter steps once per clock from zero up to the active period value and then returns to zero. One period therefore lasts period+1 clocks.
- R3: `aux_out` is high in the clock after each count c with start <= c < end. Here start and end are the clamped auxiliary marks of R10.
- R4: `main_out` is high in the clock after each count c >= main mark, unless the limit of R7 is in force.
- R5: A write with `cfg_we` high stores `cfg_data` in the staging slot picked by `cfg_sel`. The slots are 0 = period, 1 = auxiliary start, 2 = auxiliary end, 3 = main mark. Staging writes have no effect on the outputs until a commit.
- R6: A `cfg_commit` pulse copies the staging set, as it stood before any write in the same clock, into a pending set. The pending set becomes active at the next wrap, and the first count zero after that wrap already uses it. A commit in the same clock as a wrap waits for the following wrap.
- R7: A rising edge on `limit_in` seen while count >= main mark forces `main_out` low from the next clock until the period ends. The main output resumes normal operation in the next period.
- R8: The limit input never changes the counter, the period length or `aux_out`.
- R9: A rising edge on `limit_in` while count < main mark is ignored. A level that stays high creates no new edge.
- R10: Each period the block uses end = min(auxiliary end, main mark) and start = min(auxiliary start, end).
- R11: `aux_out` and `main_out` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the default timing set |
| run_en | input | 1 | Run enable; low holds the outputs low and the counter at zero |
| cfg_we | input | 1 | Staging write strobe |
| cfg_sel | input | 2 | Staging slot: 0 period, 1 aux start, 2 aux end, 3 main mark |
| cfg_data | input | 16 | Staging write value |
| cfg_commit | input | 1 | Moves the staging set into the pending set |
| limit_in | input | 1 | Cycle-by-cycle limit; rising edge ends the main on-phase |
| aux_out | output | 1 | Auxiliary pulse output (registered) |
| main_out | output | 1 | Main switch output (registered) |

## Verification
The bench fires limit edges early, inside and late in the main phase, and also holds the limit high across period boundaries. A design that reset the counter on a limit event would shorten the period and shift the next auxiliary pulse. A latch that never cleared would leave `main_out` dead in later periods. The bench also commits in clocks on and near the wrap, and leaves sets staged but not committed. A design that transferred on commit, or that took a partial set, would show a jump in the auxiliary off-time in the middle of a period. Out-of-order marks check that the clamp keeps the two outputs apart, and toggling the enable in mid-period checks the restart from count zero.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned CW = 16;
  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    SLOT_PERIOD = 2'd0,
    SLOT_START  = 2'd1,
    SLOT_END    = 2'd2,
    SLOT_MARK   = 2'd3
  } slot_e;

  typedef struct packed {
    cnt_t period;
    cnt_t start;
    cnt_t stop;
    cnt_t mark;
  } tset_t;

  function automatic cnt_t umin(input cnt_t a, input cnt_t b);
    return (a < b) ? a : b;
  endfunction

  // auxiliary end never passes the main mark
  function automatic cnt_t clamp_end(input tset_t s);
    return umin(s.stop, s.mark);
  endfunction

  // auxiliary start never passes the clamped end
  function automatic cnt_t clamp_start(input tset_t s);
    return umin(s.start, clamp_end(s));
  endfunction

  function automatic logic in_aux(input cnt_t c, input tset_t s);
    return (c >= clamp_start(s)) && (c < clamp_end(s));
  endfunction

  function automatic logic in_main(input cnt_t c, input tset_t s);
    return c >= s.mark;
  endfunction
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter cnt_t DEF_PERIOD = cnt_t'(49),
  parameter cnt_t DEF_START  = cnt_t'(5),
  parameter cnt_t DEF_END    = cnt_t'(20),
  parameter cnt_t DEF_MARK   = cnt_t'(30)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  cnt_t       cfg_data,
  input  logic       cfg_commit,
  input  logic       wrap,
  output tset_t      act
);
  localparam tset_t DEF_SET = '{period: DEF_PERIOD, start: DEF_START,
                                stop: DEF_END, mark: DEF_MARK};

  tset_t stage_q, pend_q;
  logic  pend_vld;
  logic  take_pend;

  assign take_pend = wrap && pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= DEF_SET;
    end else if (cfg_we) begin
      unique case (slot_e'(cfg_sel))
        SLOT_PERIOD: stage_q.period <= cfg_data;
        SLOT_START:  stage_q.start  <= cfg_data;
        SLOT_END:    stage_q.stop   <= cfg_data;
        SLOT_MARK:   stage_q.mark   <= cfg_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= DEF_SET;
      pend_vld <= 1'b0;
    end else begin
      if (cfg_commit) pend_q <= stage_q;
      if (cfg_commit)     pend_vld <= 1'b1;
      else if (take_pend) pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act <= DEF_SET;
    else if (take_pend) act <= pend_q;
  end

  // R6: the active set only moves on a period boundary
  a_r6_set_stable_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act));
  // R6: a commit always leaves a transfer pending
  a_r6_commit_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> pend_vld);
endmodule

// File: rtl/dpwm_counter.sv
module dpwm_counter
  import dpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  cnt_t period,
  output cnt_t cnt,
  output logic wrap
);
  assign wrap = run_en && (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_en || wrap)  cnt <= '0;
    else                       cnt <= cnt + cnt_t'(1);
  end

  // R2: the count never runs past the active period
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period);
  // R2/R8: inside a period the counter only steps by one, whatever the limit does
  a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !wrap) |=> (cnt == $past(cnt) + cnt_t'(1)));
  // R1: disabled means the count sits at zero
  a_r1_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0));
endmodule

// File: rtl/dpwm_outputs.sv
module dpwm_outputs
  import dpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  cnt_t  cnt,
  input  logic  wrap,
  input  tset_t act,
  input  logic  limit_in,
  output logic  aux_out,
  output logic  main_out,
  output logic  lim_hold
);
  logic lim_q;
  logic lim_edge;
  logic main_phase;
  logic lim_hit;
  logic aux_d, main_d;

  assign lim_edge   = limit_in && !lim_q;
  assign main_phase = in_main(cnt, act);
  assign lim_hit    = lim_edge && main_phase;
  assign aux_d      = run_en && in_aux(cnt, act);
  assign main_d     = run_en && main_phase && !lim_hold && !lim_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q    <= 1'b0;
      lim_hold <= 1'b0;
      aux_out  <= 1'b0;
      main_out <= 1'b0;
    end else begin
      lim_q <= limit_in;
      if (!run_en || wrap) lim_hold <= 1'b0;
      else if (lim_hit)    lim_hold <= 1'b1;
      aux_out  <= aux_d;
      main_out <= main_d;
    end
  end

  // R11: the two outputs never overlap
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(aux_out && main_out));
  // R7: while the limit latch is set the main output stays low
  a_r7_hold_blocks_main: assert property (@(posedge clk) disable iff (!rst_n)
    lim_hold |-> !main_out);
  // R1: disabled gives low outputs in the next clock
  a_r1_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!aux_out && !main_out));
  // R4: no main pulse before its mark
  a_r4_main_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !main_phase |=> !main_out);
  // R7: the latch is gone once a new period starts
  a_r7_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !lim_hold);
endmodule

// File: rtl/dpwm_interlock.sv
module dpwm_interlock
  import dpwm_pkg::*;
#(
  parameter cnt_t DEF_PERIOD = cnt_t'(49),
  parameter cnt_t DEF_START  = cnt_t'(5),
  parameter cnt_t DEF_END    = cnt_t'(20),
  parameter cnt_t DEF_MARK   = cnt_t'(30)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  input  logic          cfg_commit,
  input  logic          limit_in,
  output logic          aux_out,
  output logic          main_out
);
  tset_t act;
  cnt_t  cnt;
  logic  wrap;
  logic  lim_hold;

  dpwm_regs #(
    .DEF_PERIOD(DEF_PERIOD), .DEF_START(DEF_START),
    .DEF_END(DEF_END), .DEF_MARK(DEF_MARK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit), .wrap(wrap), .act(act)
  );

  dpwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(act.period),
    .cnt(cnt), .wrap(wrap)
  );

  dpwm_outputs u_out (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt(cnt), .wrap(wrap),
    .act(act), .limit_in(limit_in), .aux_out(aux_out),
    .main_out(main_out), .lim_hold(lim_hold)
  );

  // R10: the clamped auxiliary window closes no later than the main mark
  a_r10_window_order: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_start(act) <= clamp_end(act)) && (clamp_end(act) <= act.mark));
  // R7: a latched limit comes only from an edge inside the main phase
  a_r7_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lim_hold) |-> $past(cnt >= act.mark));
endmodule

// File: tb/dpwm_interlock_test.sv
module dpwm_interlock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_data = '0;
  logic        cfg_commit = 1'b0;
  logic        limit_in = 1'b0;
  logic        aux_out, main_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  dpwm_interlock uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_commit(cfg_commit),
    .limit_in(limit_in), .aux_out(aux_out), .main_out(main_out)
  );

  // behavioural reference: arrays of ints indexed by slot number
  int stg[4] = '{49, 5, 20, 30};
  int pnd[4] = '{49, 5, 20, 30};
  int cur[4] = '{49, 5, 20, 30};
  bit pnd_ok = 0;
  int m_cnt = 0;
  bit m_limq = 0, m_hold = 0, m_aux = 0, m_main = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      stg = '{49, 5, 20, 30}; pnd = stg; cur = stg; pnd_ok = 0;
      m_cnt = 0; m_limq = 0; m_hold = 0; m_aux = 0; m_main = 0;
    end else begin
      int hi, lo;
      bit at_end, late, edge_seen;
      at_end = run_en && (m_cnt >= cur[0]);
      hi = (cur[2] < cur[3]) ? cur[2] : cur[3];
      lo = (cur[1] < hi) ? cur[1] : hi;
      late = m_cnt >= cur[3];
      edge_seen = limit_in && !m_limq && late;
      m_aux  = run_en && (m_cnt >= lo) && (m_cnt < hi);
      m_main = run_en && late && !m_hold && !edge_seen;
      if (!run_en || at_end) m_hold = 0;
      else if (edge_seen)    m_hold = 1;
      m_limq = limit_in;
      if (at_end && pnd_ok) begin cur = pnd; pnd_ok = 0; end
      if (cfg_commit) begin pnd = stg; pnd_ok = 1; end
      if (cfg_we) stg[cfg_sel] = int'(cfg_data);
      m_cnt = (!run_en || at_end) ? 0 : m_cnt + 1;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (aux_out !== m_aux) begin
      fails++;
      $display("FAIL R3 aux_out [%s] t=%0t actual=%b expected=%b", phase, $time, aux_out, m_aux);
    end
    checks++;
    if (main_out !== m_main) begin
      fails++;
      $display("FAIL R4 main_out [%s] t=%0t actual=%b expected=%b", phase, $time, main_out, m_main);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit_now();
    @(negedge clk); cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
  endtask

  task automatic pulse_limit(input int width);
    @(negedge clk); limit_in = 1'b1;
    repeat (width) @(negedge clk);
    limit_in = 1'b0;
  endtask

  // R2/R8: clocks between two rising edges of aux_out, seen at the port
  task automatic period_check(input string tag, input int expect_len);
    int n = 0;
    bit prev;
    prev = aux_out;
    while (!(aux_out && !prev)) begin prev = aux_out; @(negedge clk); end
    prev = aux_out;
    @(negedge clk);
    n = 1;
    while (!(aux_out && !prev)) begin prev = aux_out; @(negedge clk); n++; end
    checks++;
    if (n != expect_len) begin
      fails++;
      $display("FAIL %s period actual=%0d expected=%0d", tag, n, expect_len);
    end
  endtask

  initial begin
    phase = "R1 reset";
    idle(4);
    checks++;
    if (aux_out !== 1'b0 || main_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", aux_out, main_out);
    end
    rst_n = 1'b1;
    idle(6);
    phase = "R2 default run";
    run_en = 1'b1;
    idle(120);
    period_check("R2", 50);

    phase = "R5 staged only";
    wr(0, 29); wr(1, 3); wr(2, 10); wr(3, 15);
    idle(110);
    period_check("R5", 50);

    phase = "R6 commit";
    commit_now();
    idle(70);
    period_check("R6", 30);

    phase = "R7 limit in main phase";
    for (int k = 0; k < 12; k++) begin
      idle(3 + k * 2);
      pulse_limit(1 + (k % 3));
    end
    phase = "R8 limit period";
    fork
      period_check("R8", 30);
      begin idle(22); pulse_limit(2); end
    join

    phase = "R9 limit held high";
    @(negedge clk); limit_in = 1'b1;
    idle(75);
    limit_in = 1'b0;
    idle(17);
    pulse_limit(40);
    idle(30);

    phase = "R10 out of order";
    wr(1, 12); wr(2, 25); wr(3, 8); wr(0, 19);
    commit_now();
    idle(60);
    for (int k = 0; k < 6; k++) begin idle(5 + k); pulse_limit(1); end
    wr(1, 9); wr(2, 4); wr(3, 14);
    commit_now();
    idle(60);

    phase = "R6 commit sweep";
    wr(0, 11); wr(1, 2); wr(2, 5); wr(3, 7);
    for (int k = 0; k < 14; k++) begin
      wr(0, 11 + (k % 3)); wr(3, 6 + (k % 4));
      idle(k);
      commit_now();
    end
    idle(40);

    phase = "R1 enable toggle";
    for (int k = 0; k < 5; k++) begin
      idle(7 + 3 * k);
      run_en = 1'b0;
      idle(3);
      checks++;
      if (aux_out !== 1'b0 || main_out !== 1'b0) begin
        fails++;
        $display("FAIL R1 disabled outputs actual=%b%b expected=00", aux_out, main_out);
      end
      run_en = 1'b1;
    end
    idle(40);

    phase = "R11 final";
    idle(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule